// File: doc/BRIEF.md
# Buddy Page Allocator

This block hands out and takes back runs of I/O virtual pages from a region whose size is a power of two. A request asks either for a run of some page count, and gets back the first page of a naturally aligned block, or returns such a block, which is then merged with its neighbours wherever possible. All allocator state lives in the block: one head pointer per size class, plus a per-block metadata store. Each store entry holds the order, an in-use flag, a valid flag and two link fields.

The region is handled in granules of four pages. A block of order k covers 4<<k pages. Free blocks of each order form a doubly linked list, with granule 0 used as the null link. Granule 0 is reserved for good after reset, so it never takes part in allocation or merging. Requests are served one at a time. A request is taken while `req_ready` is high, and each request gets exactly one single-cycle response.

Top module: `buddy_page_alloc`

## Requirements
- R1: After reset `req_ready` is 1 and `busy` and `resp_valid` are 0. The region starts as one free block per order k at page 4<<k, and granule 0 is reserved, so the first one-page allocation returns page 4.
- R2: A request's size is the page count plus one guard page, raised to at least 4 and then rounded up to the next power of two. The order is log2 of that size minus 2.
- R3: An allocation whose padded size is half the region or more is answered with status 1 (too big), and allocator state is left unchanged.
- R4: An allocation takes the head block of the lowest non-empty free list whose order is at least the needed order.
- R5: When the taken block is larger than needed, it is halved until it reaches the needed order. At each step the upper half goes onto the free list of its order, where later requests of that order find it.
- R6: An allocation that finds every sufficient list empty is answered with status 2 (no space).
- R7: On free, the partner granule is the block's granule index XOR (1<<order). Merging continues only while the partner is not valid, not in use and recorded at the same order. The partner is unlinked, the lower index is kept and the order rises by one. Merging never goes past the top order.
- R8: A freed or merged block is inserted at the head of its list, so the next allocation of that order returns it.
- R9: A free whose padded size is half the region or more is ignored. It is answered with status 0, and no list changes.
- R10: While a request is being processed, `busy` is 1 and `req_ready` is 0. An allocation that needs a split or a list update raises `busy` in the cycle after acceptance.
- R11: Status codes are 0 (ok), 1 (too big) and 2 (no space). An ok allocation returns a nonzero page index with its two low bits zero. Free responses return index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_free | input | 1 | 1 = free, 0 = allocate |
| req_pages | input | PAGE_W+1 | Page count of the request |
| req_index | input | PAGE_W | First page of the block being freed |
| busy | output | 1 | A request is in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 2 | 0 ok, 1 too big, 2 no space |
| resp_index | output | PAGE_W | First page of the allocated block, 0 for frees |

## Verification
The assertions assume that every free names the first page of a block that is currently allocated, with the same page count used to allocate it, and never names page 0. They also assume that requests are raised only while `req_ready` is high. The stimulus keeps a table of outstanding allocations and draws each free from that table, using the recorded count. Oversized frees are issued only against blocks that are still live, because they must change nothing.

// File: rtl/bd_pkg.sv
package bd_pkg;

   typedef enum logic [1:0] {
      BD_OK       = 2'd0,
      BD_TOO_BIG  = 2'd1,
      BD_NO_SPACE = 2'd2
   } bd_status_e;

   // floor(log2(v)) for v >= 1, 0 for v == 0
   function automatic int bd_log2(input int v);
      int r;
      r = 0;
      for (int k = 0; k < 31; k++) begin
         if ((32'sd1 <<< k) <= v) r = k;
      end
      return r;
   endfunction

endpackage

// File: rtl/bd_order_calc.sv
module bd_order_calc #(
   parameter int PAGE_W = 8,
   parameter int CNT_W  = PAGE_W + 1,
   parameter int NORD   = PAGE_W - 2,
   parameter int ORD_W  = 3
) (
   input  logic [CNT_W-1:0] count,
   output logic [ORD_W-1:0] order,
   output logic             too_big
);

   localparam int PW = CNT_W + 1;

   logic [PW-1:0] padded;

   always_comb begin
      padded = {1'b0, count} + PW'(1);
      if (padded < PW'(4)) padded = PW'(4);
      too_big = padded >= (PW'(1) << (PAGE_W - 1));
      order = '0;
      for (int z = NORD - 1; z >= 0; z--) begin
         if ((PW'(4) << z) >= padded) order = ORD_W'(z);
      end
   end

   // R2: the chosen order must cover the padded size
   always_comb begin
      if (!too_big) begin
         a_order_fits_r2: assert ((PW'(4) << order) >= padded);
      end
   end

endmodule

// File: rtl/bd_list_scan.sv
module bd_list_scan #(
   parameter int NORD   = 6,
   parameter int ORD_W  = 3,
   parameter int UNIT_W = 6
) (
   input  logic [UNIT_W-1:0] heads [NORD],
   input  logic [ORD_W-1:0]  start,
   output logic              found,
   output logic [ORD_W-1:0]  hit
);

   logic [NORD-1:0] nonempty;

   for (genvar g = 0; g < NORD; g++) begin : g_nz
      assign nonempty[g] = (heads[g] != '0);
   end

   always_comb begin
      found = 1'b0;
      hit   = '0;
      for (int z = NORD - 1; z >= 0; z--) begin
         if (nonempty[z] && (ORD_W'(z) >= start)) begin
            found = 1'b1;
            hit   = ORD_W'(z);
         end
      end
   end

   // R4: the hit is a non-empty list at or above the start order
   always_comb begin
      if (found) begin
         a_scan_hit_r4: assert (nonempty[hit] && (hit >= start));
      end
   end

endmodule

// File: rtl/bd_meta_store.sv
module bd_meta_store
   import bd_pkg::*;
#(
   parameter int UNITS  = 64,
   parameter int UNIT_W = 6,
   parameter int ORD_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [UNIT_W-1:0] rd_addr,
   output logic              rd_val,
   output logic              rd_used,
   output logic [ORD_W-1:0]  rd_ord,
   output logic [UNIT_W-1:0] rd_next,
   output logic [UNIT_W-1:0] rd_prev,
   input  logic              we,
   input  logic [UNIT_W-1:0] wr_addr,
   input  logic              wr_val,
   input  logic              wr_used,
   input  logic [ORD_W-1:0]  wr_ord,
   input  logic [UNIT_W-1:0] wr_next,
   input  logic [UNIT_W-1:0] wr_prev
);

   logic [UNITS-1:0]  val_q;
   logic [UNITS-1:0]  used_q;
   logic [ORD_W-1:0]  ord_q  [UNITS];
   logic [UNIT_W-1:0] next_q [UNITS];
   logic [UNIT_W-1:0] prev_q [UNITS];

   assign rd_val  = val_q[rd_addr];
   assign rd_used = used_q[rd_addr];
   assign rd_ord  = ord_q[rd_addr];
   assign rd_next = next_q[rd_addr];
   assign rd_prev = prev_q[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < UNITS; i++) begin
            val_q[i]  <= 1'b0;
            used_q[i] <= (i == 0);
            ord_q[i]  <= (i != 0 && (i & (i - 1)) == 0) ? ORD_W'(bd_log2(i)) : '0;
            next_q[i] <= '0;
            prev_q[i] <= '0;
         end
      end else if (we) begin
         val_q[wr_addr]  <= wr_val;
         used_q[wr_addr] <= wr_used;
         ord_q[wr_addr]  <= wr_ord;
         next_q[wr_addr] <= wr_next;
         prev_q[wr_addr] <= wr_prev;
      end
   end

endmodule

// File: rtl/buddy_page_alloc.sv
module buddy_page_alloc
   import bd_pkg::*;
#(
   parameter  int REGION_PAGES = 256,
   localparam int PAGE_W       = $clog2(REGION_PAGES),
   localparam int CNT_W        = PAGE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_free,
   input  logic [CNT_W-1:0]  req_pages,
   input  logic [PAGE_W-1:0] req_index,
   output logic              busy,
   output logic              resp_valid,
   output logic [1:0]        resp_status,
   output logic [PAGE_W-1:0] resp_index
);

   localparam int UNITS  = REGION_PAGES / 4;
   localparam int UNIT_W = PAGE_W - 2;
   localparam int NORD   = PAGE_W - 2;
   localparam int ORD_W  = $clog2(NORD);

   if (REGION_PAGES < 32 || (REGION_PAGES & (REGION_PAGES - 1)) != 0) begin : g_bad_region
      $error("REGION_PAGES must be a power of two of at least 32");
   end

   typedef enum logic [3:0] {
      S_IDLE, S_SPLIT, S_TAKE, S_UNPOP, S_CHECK, S_UNL_P, S_UNL_N, S_INS, S_LINK
   } bd_state_e;

   bd_state_e         state_q;
   logic [UNIT_W-1:0] blk_q, lnk_n_q, lnk_p_q, old_head_q;
   logic [ORD_W-1:0]  cur_q, tgt_q, top_q;
   logic [UNIT_W-1:0] head_q [NORD];
   logic              resp_valid_q, resp_alloc_q;
   logic [1:0]        resp_status_q;
   logic [PAGE_W-1:0] resp_index_q;

   logic [ORD_W-1:0]  need_ord, scan_hit;
   logic              too_big, scan_found, accept;

   logic [UNIT_W-1:0] rd_addr, rd_next, rd_prev;
   logic              rd_val, rd_used;
   logic [ORD_W-1:0]  rd_ord;
   logic              we, wr_val, wr_used;
   logic [UNIT_W-1:0] wr_addr, wr_next, wr_prev;
   logic [ORD_W-1:0]  wr_ord;

   logic [UNIT_W-1:0] pair_w, split_blk;
   logic [ORD_W-1:0]  split_ord;

   assign req_ready   = (state_q == S_IDLE);
   assign busy        = (state_q != S_IDLE);
   assign accept      = req_valid && req_ready;
   assign resp_valid  = resp_valid_q;
   assign resp_status = resp_status_q;
   assign resp_index  = resp_index_q;

   assign pair_w    = blk_q ^ (UNIT_W'(1) << cur_q);
   assign split_ord = cur_q - ORD_W'(1);
   assign split_blk = blk_q | (UNIT_W'(1) << split_ord);

   bd_order_calc #(
      .PAGE_W(PAGE_W), .CNT_W(CNT_W), .NORD(NORD), .ORD_W(ORD_W)
   ) u_order (
      .count(req_pages), .order(need_ord), .too_big(too_big)
   );

   bd_list_scan #(
      .NORD(NORD), .ORD_W(ORD_W), .UNIT_W(UNIT_W)
   ) u_scan (
      .heads(head_q), .start(need_ord), .found(scan_found), .hit(scan_hit)
   );

   bd_meta_store #(
      .UNITS(UNITS), .UNIT_W(UNIT_W), .ORD_W(ORD_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(rd_addr), .rd_val(rd_val), .rd_used(rd_used), .rd_ord(rd_ord),
      .rd_next(rd_next), .rd_prev(rd_prev),
      .we(we), .wr_addr(wr_addr), .wr_val(wr_val), .wr_used(wr_used),
      .wr_ord(wr_ord), .wr_next(wr_next), .wr_prev(wr_prev)
   );

   // read address selection
   always_comb begin
      case (state_q)
         S_UNPOP: rd_addr = lnk_n_q;
         S_CHECK: rd_addr = pair_w;
         S_UNL_P: rd_addr = lnk_p_q;
         S_UNL_N: rd_addr = lnk_n_q;
         S_LINK:  rd_addr = old_head_q;
         default: rd_addr = blk_q;
      endcase
   end

   // single write port; link edits are read-modify-write of one field
   always_comb begin
      we      = 1'b0;
      wr_addr = blk_q;
      wr_val  = 1'b0;
      wr_used = 1'b0;
      wr_ord  = cur_q;
      wr_next = '0;
      wr_prev = '0;
      case (state_q)
         S_SPLIT: begin
            we      = 1'b1;
            wr_addr = split_blk;
            wr_ord  = split_ord;
         end
         S_TAKE: begin
            we      = 1'b1;
            wr_val  = 1'b1;
            wr_used = 1'b1;
            wr_ord  = tgt_q;
         end
         S_UNPOP: begin
            we      = 1'b1;
            wr_addr = lnk_n_q;
            wr_val  = rd_val;
            wr_used = rd_used;
            wr_ord  = rd_ord;
            wr_next = rd_next;
         end
         S_UNL_P: begin
            we      = (lnk_p_q != '0);
            wr_addr = lnk_p_q;
            wr_val  = rd_val;
            wr_used = rd_used;
            wr_ord  = rd_ord;
            wr_next = lnk_n_q;
            wr_prev = rd_prev;
         end
         S_UNL_N: begin
            we      = (lnk_n_q != '0);
            wr_addr = lnk_n_q;
            wr_val  = rd_val;
            wr_used = rd_used;
            wr_ord  = rd_ord;
            wr_next = rd_next;
            wr_prev = lnk_p_q;
         end
         S_INS: begin
            we      = 1'b1;
            wr_next = head_q[cur_q];
         end
         S_LINK: begin
            we      = 1'b1;
            wr_addr = old_head_q;
            wr_val  = rd_val;
            wr_used = rd_used;
            wr_ord  = rd_ord;
            wr_next = rd_next;
            wr_prev = blk_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= S_IDLE;
         blk_q         <= '0;
         lnk_n_q       <= '0;
         lnk_p_q       <= '0;
         old_head_q    <= '0;
         cur_q         <= '0;
         tgt_q         <= '0;
         top_q         <= '0;
         resp_valid_q  <= 1'b0;
         resp_alloc_q  <= 1'b0;
         resp_status_q <= BD_OK;
         resp_index_q  <= '0;
         for (int e = 0; e < NORD; e++) head_q[e] <= UNIT_W'(1) << e;
      end else begin
         resp_valid_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (accept) begin
                  resp_alloc_q <= !req_free;
                  if (!req_free) begin
                     if (too_big) begin
                        resp_valid_q  <= 1'b1;
                        resp_status_q <= BD_TOO_BIG;
                        resp_index_q  <= '0;
                     end else if (!scan_found) begin
                        resp_valid_q  <= 1'b1;
                        resp_status_q <= BD_NO_SPACE;
                        resp_index_q  <= '0;
                     end else begin
                        blk_q   <= head_q[scan_hit];
                        cur_q   <= scan_hit;
                        top_q   <= scan_hit;
                        tgt_q   <= need_ord;
                        state_q <= (scan_hit != need_ord) ? S_SPLIT : S_TAKE;
                     end
                  end else if (too_big) begin
                     resp_valid_q  <= 1'b1;
                     resp_status_q <= BD_OK;
                     resp_index_q  <= '0;
                  end else begin
                     blk_q   <= req_index[PAGE_W-1:2];
                     cur_q   <= need_ord;
                     state_q <= S_CHECK;
                  end
               end
            end
            S_SPLIT: begin
               head_q[split_ord] <= split_blk;
               cur_q             <= split_ord;
               if (split_ord == tgt_q) state_q <= S_TAKE;
            end
            S_TAKE: begin
               head_q[top_q] <= rd_next;
               lnk_n_q       <= rd_next;
               if (rd_next != '0) begin
                  state_q <= S_UNPOP;
               end else begin
                  state_q       <= S_IDLE;
                  resp_valid_q  <= 1'b1;
                  resp_status_q <= BD_OK;
                  resp_index_q  <= {blk_q, 2'b00};
               end
            end
            S_UNPOP: begin
               state_q       <= S_IDLE;
               resp_valid_q  <= 1'b1;
               resp_status_q <= BD_OK;
               resp_index_q  <= {blk_q, 2'b00};
            end
            S_CHECK: begin
               if (cur_q == ORD_W'(NORD - 1) || rd_val || rd_used || rd_ord != cur_q) begin
                  state_q <= S_INS;
               end else begin
                  lnk_n_q <= rd_next;
                  lnk_p_q <= rd_prev;
                  state_q <= S_UNL_P;
               end
            end
            S_UNL_P: begin
               if (lnk_p_q == '0) head_q[cur_q] <= lnk_n_q;
               state_q <= S_UNL_N;
            end
            S_UNL_N: begin
               blk_q   <= blk_q & ~(UNIT_W'(1) << cur_q);
               cur_q   <= cur_q + ORD_W'(1);
               state_q <= S_CHECK;
            end
            S_INS: begin
               old_head_q    <= head_q[cur_q];
               head_q[cur_q] <= blk_q;
               if (head_q[cur_q] != '0) begin
                  state_q <= S_LINK;
               end else begin
                  state_q       <= S_IDLE;
                  resp_valid_q  <= 1'b1;
                  resp_status_q <= BD_OK;
                  resp_index_q  <= '0;
               end
            end
            S_LINK: begin
               state_q       <= S_IDLE;
               resp_valid_q  <= 1'b1;
               resp_status_q <= BD_OK;
               resp_index_q  <= '0;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   p_reject_big_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_free && too_big) |=> (resp_valid && resp_status == BD_TOO_BIG));

   p_no_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_free && !too_big && !scan_found) |=> (resp_valid && resp_status == BD_NO_SPACE));

   p_split_above_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_SPLIT) |-> (cur_q > tgt_q));

   p_merge_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_UNL_N) |=> (state_q == S_CHECK && cur_q == $past(cur_q) + ORD_W'(1)));

   p_ignore_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_free && too_big) |=> (resp_valid && resp_status == BD_OK && !busy));

   p_alloc_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_free && !too_big && scan_found) |=> (busy && !req_ready));

   p_alloc_index_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_alloc_q && resp_status == BD_OK) |-> (resp_index[1:0] == 2'b00 && resp_index != '0));

endmodule

// File: tb/buddy_page_alloc_test.sv
module buddy_page_alloc_test;

   localparam int CLK_PERIOD = 10;
   localparam int P      = 256;
   localparam int PAGE_W = $clog2(P);
   localparam int CNT_W  = PAGE_W + 1;
   localparam int UNITS  = P / 4;
   localparam int NORD   = PAGE_W - 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_free = 1'b0;
   logic [CNT_W-1:0] req_pages = '0;
   logic [PAGE_W-1:0] req_index = '0;
   logic req_ready, busy, resp_valid;
   logic [1:0] resp_status;
   logic [PAGE_W-1:0] resp_index;

   int n_chk = 0;
   int n_fail = 0;

   int m_ord [UNITS];
   bit m_used [UNITS];
   bit m_val [UNITS];
   int m_nxt [UNITS];
   int m_prv [UNITS];
   int m_head [NORD];

   int o_idx [64];
   int o_cnt [64];
   int n_out = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   buddy_page_alloc #(.REGION_PAGES(P)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_free(req_free), .req_pages(req_pages), .req_index(req_index),
      .busy(busy), .resp_valid(resp_valid), .resp_status(resp_status),
      .resp_index(resp_index)
   );

   task automatic check(string rq, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic void m_init();
      for (int i = 0; i < UNITS; i++) begin
         m_used[i] = (i == 0);
         m_val[i]  = 1'b0;
         m_nxt[i]  = 0;
         m_prv[i]  = 0;
         m_ord[i]  = 0;
      end
      for (int e = 0; e < NORD; e++) begin
         m_head[e] = 1 << e;
         m_ord[1 << e] = e;
      end
   endfunction

   function automatic void m_size(int cnt, output bit big, output int ord);
      int p;
      p = cnt + 1;
      if (p < 4) p = 4;
      big = (p >= P / 2);
      ord = 0;
      while ((4 << ord) < p) ord++;
   endfunction

   function automatic void m_alloc(int cnt, output int st, output int idx);
      bit big;
      int o, z, r, t, nx;
      m_size(cnt, big, o);
      idx = 0;
      if (big) begin st = 1; return; end
      z = o;
      while (z < NORD && m_head[z] == 0) z++;
      if (z == NORD) begin st = 2; return; end
      r = m_head[z];
      for (int e = z - 1; e >= o; e--) begin
         t = r + (1 << e);
         m_ord[t] = e; m_val[t] = 0; m_used[t] = 0; m_nxt[t] = 0; m_prv[t] = 0;
         m_head[e] = t;
      end
      nx = m_nxt[r];
      m_ord[r] = o; m_val[r] = 1; m_used[r] = 1; m_nxt[r] = 0; m_prv[r] = 0;
      m_head[z] = nx;
      if (nx != 0) m_prv[nx] = 0;
      st = 0;
      idx = r * 4;
   endfunction

   function automatic void m_free(int idx, int cnt);
      bit big;
      int o, u, pr, n, p, oh;
      m_size(cnt, big, o);
      if (big) return;
      u = idx >> 2;
      while (o < NORD - 1) begin
         pr = u ^ (1 << o);
         if (m_val[pr] || m_used[pr] || m_ord[pr] != o) break;
         n = m_nxt[pr];
         p = m_prv[pr];
         if (p != 0) m_nxt[p] = n; else m_head[o] = n;
         if (n != 0) m_prv[n] = p;
         u = u & ~(1 << o);
         o++;
      end
      oh = m_head[o];
      m_ord[u] = o; m_val[u] = 0; m_used[u] = 0; m_nxt[u] = oh; m_prv[u] = 0;
      m_head[o] = u;
      if (oh != 0) m_prv[oh] = u;
   endfunction

   // drive one request, wait for its response; bsy = busy one cycle after acceptance
   task automatic issue(bit fr, int cnt, int idx, string rq,
                        output int st, output int ri, output bit bsy);
      int lat;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_free  = fr;
      req_pages = CNT_W'(cnt);
      req_index = PAGE_W'(idx);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      bsy = busy;
      lat = 1;
      while (!resp_valid && lat < 300) begin
         @(negedge clk);
         lat++;
      end
      check(rq, "response arrived", int'(resp_valid), 1);
      st = resp_status;
      ri = resp_index;
   endtask

   // request checked against the bench model
   task automatic run(bit fr, int cnt, int idx, string rq, output int st, output int ri);
      int est, eidx;
      bit bsy;
      if (fr) begin
         m_free(idx, cnt);
         est = 0;
         eidx = 0;
      end else begin
         m_alloc(cnt, est, eidx);
      end
      issue(fr, cnt, idx, rq, st, ri, bsy);
      check(rq, "status", st, est);
      check(rq, "index", ri, eidx);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int st, ri, k;
      bit bsy;
      void'($urandom(32'h1d2c3b4a));
      m_init();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "req_ready", int'(req_ready), 1);
      check("R1", "busy", int'(busy), 0);
      check("R1", "resp_valid", int'(resp_valid), 0);

      // R1 R2: one page pads to four, first free granule is page 4
      run(0, 1, 0, "R1", st, ri);
      check("R2", "first block page", ri, 4);

      // R5 R10: 3 pages needs order 0, list 0 empty, split order-1 block at page 8
      m_alloc(3, st, ri);
      issue(0, 3, 0, "R10", st, ri, bsy);
      check("R10", "busy after accept", int'(bsy), 1);
      check("R5", "split lower half page", ri, 8);
      check("R11", "status ok", st, 0);
      @(negedge clk);
      check("R10", "single response pulse", int'(resp_valid), 0);

      // R5: upper half of the split (page 12) is now on list 0
      run(0, 0, 0, "R5", st, ri);
      check("R5", "upper half reused", ri, 12);

      // R2 R4: 4 pages pad to 5 -> 8 pages, taken from order 2 at page 16
      run(0, 4, 0, "R4", st, ri);
      check("R4", "order-2 split page", ri, 16);

      // R3: 127 + 1 reaches half the region
      run(0, 127, 0, "R3", st, ri);
      check("R3", "too big status", st, 1);
      // largest legal request
      run(0, 126, 0, "R2", st, ri);
      check("R2", "largest block page", ri, 128);

      // R8: free and reallocate the top block
      run(1, 126, 128, "R8", st, ri);
      run(0, 100, 0, "R8", st, ri);
      check("R8", "reinserted block", ri, 128);

      // R9: oversized free leaves the live block in place, so the top order stays empty
      run(1, 200, 128, "R9", st, ri);
      check("R9", "ignored free status", st, 0);
      run(0, 126, 0, "R6", st, ri);
      check("R6", "no space status", st, 2);

      // R7: page 12 stays alone (partner page 8 in use), page 8 then merges with it
      run(1, 0, 12, "R7", st, ri);
      run(1, 3, 8, "R7", st, ri);
      run(0, 4, 0, "R8", st, ri);
      check("R7", "merged order-1 block", ri, 8);
      // R7: page 16 merges with free partner page 24 into order 2
      run(1, 4, 16, "R7", st, ri);
      run(0, 12, 0, "R7", st, ri);
      check("R7", "merged order-2 block", ri, 16);

      // release directed blocks
      run(1, 1, 4, "R7", st, ri);
      run(1, 4, 8, "R7", st, ri);
      run(1, 12, 16, "R7", st, ri);
      run(1, 100, 128, "R7", st, ri);

      // random mix against the model
      for (int it = 0; it < 400; it++) begin
         if (n_out > 0 && ($urandom % 100) < 45) begin
            k = $urandom % n_out;
            if (($urandom % 16) == 0) begin
               run(1, 200, o_idx[k], "R9", st, ri);
            end else begin
               run(1, o_cnt[k], o_idx[k], "R7", st, ri);
               o_idx[k] = o_idx[n_out - 1];
               o_cnt[k] = o_cnt[n_out - 1];
               n_out--;
            end
         end else begin
            k = (($urandom % 10) < 7) ? int'($urandom % 12) : int'($urandom % 140);
            run(0, k, 0, "R4", st, ri);
            if (st == 0 && n_out < 64) begin
               o_idx[n_out] = ri;
               o_cnt[n_out] = k;
               n_out++;
            end
         end
      end

      // drain and confirm full coalescing back to the reset layout
      while (n_out > 0) begin
         run(1, o_cnt[n_out - 1], o_idx[n_out - 1], "R7", st, ri);
         n_out--;
      end
      run(0, 126, 0, "R7", st, ri);
      check("R7", "coalesced top block", ri, 128);
      run(0, 60, 0, "R7", st, ri);
      check("R7", "coalesced order-4 block", ri, 64);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule